// File: doc/BRIEF.md
# Masked Supply-Event Interrupt with Sticky Fault Capture

This block watches the event flags of four supplies: input overvoltage, input undervoltage, two output undervoltage levels and overcurrent. That makes twenty interrupt sources. Each source passes through its own enable bit. When any enabled source is active while the block is armed, a single active-low interrupt output latches low. It stays low until a dedicated clear input, which is synchronised inside the block, is driven low.

Every enabled source that is active while armed also sets a sticky fault bit. Per-supply tracking-error flags set fault bits as well, but they never drive the interrupt. The block is armed only while the power-on request is active and a programmable hold-off has run out. The hold-off is counted in millisecond ticks and starts when the request becomes active. Fault bits are ordinary flops. A register write can clear them but never set them.

All configuration and capture state sits in a small byte-wide register file with a write port and a combinational read port:

| Address | Contents |
|---|---|
| 0 to 2 | Enable bytes |
| 3 | Hold-off code |
| 4 to 6 | Fault bytes |

The enable bytes use the same bit layout as the fault bytes.

Top module: `irq_fault_capture`

## Requirements
- R1: After reset: irq_n is 1, enable bytes read 0xFF, 0xFF, 0x0F, the hold-off code reads 4, and all fault bytes read 0.
- R2: Byte layout, with supply 1 in the highest bit of each nibble. Byte 0 (address 4) holds input UV s1..s4 in bits 7..4 and input OV s1..s4 in bits 3..0. Byte 1 (address 5) holds output UV1 in bits 7..4 and output UV2 in bits 3..0. Byte 2 (address 6) holds tracking error in bits 7..4 and overcurrent in bits 3..0. Enable bytes at addresses 0..2 use the same positions. An enabled active source, while armed, drives irq_n low and sets exactly its own fault bit.
- R3: A source whose enable bit is 0 neither drives irq_n low nor sets a fault bit.
- R4: Once low, irq_n stays low after the sources go inactive, until clr_n is driven low.
- R5: While the synchronised clr_n is low, irq_n is 1 even with enabled sources active. A source still active re-asserts irq_n after clr_n is released.
- R6: While pwr_on is 0, no fault bit is set and irq_n does not go low.
- R7: Hold-off codes 0, 1, 2, 3 and 4-or-above give 0, 1, 2, 4 and 8 units of HOLD_UNIT_MS ticks, counted from pwr_on rising. Until the count expires, nothing is recorded and irq_n stays 1.
- R8: Writing a fault byte ANDs it with the written data. A 0 bit clears, a 1 bit has no effect, and fault bits never drop without a write.
- R9: Tracking-error flags set their fault bits while armed, regardless of the enable bytes, and never drive irq_n. Enable bits 7..4 of byte 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power cycle) |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| pwr_on | input | 1 | Power-on request, active high, synchronous |
| clr_n | input | 1 | Interrupt clear, active low, asynchronous |
| ev_ov_in | input | NSUP | Input overvoltage per supply |
| ev_uv_in | input | NSUP | Input undervoltage per supply |
| ev_uv1_out | input | NSUP | Output undervoltage level 1 per supply |
| ev_uv2_out | input | NSUP | Output undervoltage level 2 per supply |
| ev_oc | input | NSUP | Overcurrent per supply |
| ev_trk | input | NSUP | Tracking error per supply |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 2*NSUP | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 2*NSUP | Register read data |
| irq_n | output | 1 | Latched interrupt, active low |

## Verification
The assertions take pwr_on and the event flags to be synchronous to clk. Only clr_n is treated as asynchronous. The assertions also take tick_ms to be a plain pulse whose spacing does not matter to the checks. The stimulus changes every input on the falling clock edge, so each value is settled at the next rising edge. Ticks are issued one cycle at a time, so hold-off expiry can be checked one tick before and one tick after.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int unsigned NSUP  = 4;
    localparam int unsigned BYTEW = 2 * NSUP;
    localparam int unsigned NBYTE = 3;
    localparam int unsigned FBITS = NBYTE * BYTEW;
    localparam int unsigned AW    = 3;

    localparam logic [AW-1:0] A_EN0  = 3'd0;
    localparam logic [AW-1:0] A_HOLD = 3'd3;
    localparam logic [AW-1:0] A_FLT0 = 3'd4;

    localparam logic [2:0] HOLD_RST = 3'd4;

    // tracking-error bits occupy the upper half of the last byte
    localparam logic [FBITS-1:0] TRK_MASK = FBITS'(((1 << NSUP) - 1) << NSUP);
    localparam logic [FBITS-1:0] SRC_MASK = ~TRK_MASK;

    typedef struct packed {
        logic [FBITS-1:0] en;
        logic [2:0]       hcode;
        logic [FBITS-1:0] fault;
        logic             pend;
    } cap_state_t;
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/irqf_holdoff.sv
module irqf_holdoff #(
    parameter int unsigned UNIT_MS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       tick,
    input  logic [2:0] code,
    output logic       live
);
    localparam int unsigned CW = $clog2(8 * UNIT_MS + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          req_d, req_q;
    logic [CW-1:0] load;

    always_comb begin
        case (code)
            3'd0:    load = '0;
            3'd1:    load = CW'(UNIT_MS);
            3'd2:    load = CW'(2 * UNIT_MS);
            3'd3:    load = CW'(4 * UNIT_MS);
            default: load = CW'(8 * UNIT_MS);
        endcase
        req_d = req;
        cnt_d = cnt_q;
        if (req && !req_q)                 cnt_d = load;
        else if (tick && cnt_q != '0)      cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            req_q <= req_d;
        end
    end

    assign live = req && req_q && (cnt_q == '0);
endmodule

// File: rtl/irqf_src_pack.sv
module irqf_src_pack
    import irqf_pkg::*;
(
    input  logic [NSUP-1:0]  ov_in,
    input  logic [NSUP-1:0]  uv_in,
    input  logic [NSUP-1:0]  uv1_out,
    input  logic [NSUP-1:0]  uv2_out,
    input  logic [NSUP-1:0]  trk,
    input  logic [NSUP-1:0]  oc,
    output logic [FBITS-1:0] packed_o
);
    for (genvar k = 0; k < NSUP; k++) begin : g_sup
        assign packed_o[3*BYTEW-1-k]      = uv_in[k];
        assign packed_o[3*BYTEW-1-NSUP-k] = ov_in[k];
        assign packed_o[2*BYTEW-1-k]      = uv1_out[k];
        assign packed_o[2*BYTEW-1-NSUP-k] = uv2_out[k];
        assign packed_o[BYTEW-1-k]        = trk[k];
        assign packed_o[BYTEW-1-NSUP-k]   = oc[k];
    end
endmodule

// File: rtl/irq_fault_capture.sv
module irq_fault_capture
    import irqf_pkg::*;
#(
    parameter int unsigned HOLD_UNIT_MS = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             pwr_on,
    input  logic             clr_n,
    input  logic [NSUP-1:0]  ev_ov_in,
    input  logic [NSUP-1:0]  ev_uv_in,
    input  logic [NSUP-1:0]  ev_uv1_out,
    input  logic [NSUP-1:0]  ev_uv2_out,
    input  logic [NSUP-1:0]  ev_oc,
    input  logic [NSUP-1:0]  ev_trk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [BYTEW-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [BYTEW-1:0] rd_data,
    output logic             irq_n
);
    cap_state_t       st_d, st_q;
    logic             clr_s;
    logic             live;
    logic [FBITS-1:0] src;
    logic [FBITS-1:0] hit;
    logic [FBITS-1:0] fault_q;

    irqf_sync #(.STAGES(2)) u_clr_sync (
        .clk(clk), .rst_n(rst_n), .d(clr_n), .q(clr_s)
    );

    irqf_holdoff #(.UNIT_MS(HOLD_UNIT_MS)) u_holdoff (
        .clk(clk), .rst_n(rst_n), .req(pwr_on), .tick(tick_ms),
        .code(st_q.hcode), .live(live)
    );

    irqf_src_pack u_pack (
        .ov_in(ev_ov_in), .uv_in(ev_uv_in), .uv1_out(ev_uv1_out),
        .uv2_out(ev_uv2_out), .trk(ev_trk), .oc(ev_oc), .packed_o(src)
    );

    assign hit     = src & st_q.en;
    assign fault_q = st_q.fault;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NBYTE; b++) begin
            if (wr_en && wr_addr == A_EN0 + AW'(b))
                st_d.en[FBITS-1-b*BYTEW -: BYTEW] = wr_data;
            if (wr_en && wr_addr == A_FLT0 + AW'(b))
                st_d.fault[FBITS-1-b*BYTEW -: BYTEW] =
                    st_q.fault[FBITS-1-b*BYTEW -: BYTEW] & wr_data;
        end
        st_d.en = st_d.en & SRC_MASK;
        if (wr_en && wr_addr == A_HOLD)
            st_d.hcode = wr_data[2:0];
        if (live)
            st_d.fault = st_d.fault | hit | (src & TRK_MASK);
        if (!clr_s)
            st_d.pend = 1'b0;
        else if (live && |hit)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en    <= SRC_MASK;
            st_q.hcode <= HOLD_RST;
            st_q.fault <= '0;
            st_q.pend  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NBYTE; b++) begin
            if (rd_addr == A_EN0 + AW'(b))  rd_data = st_q.en[FBITS-1-b*BYTEW -: BYTEW];
            if (rd_addr == A_FLT0 + AW'(b)) rd_data = fault_q[FBITS-1-b*BYTEW -: BYTEW];
        end
        if (rd_addr == A_HOLD) rd_data = BYTEW'(st_q.hcode);
    end

    assign irq_n = ~st_q.pend;
endmodule

// File: rtl/irqf_chk.sv
module irqf_chk
    import irqf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_on,
    input logic             wr_en,
    input logic             clr_s,
    input logic             live,
    input logic             irq_n,
    input logic [FBITS-1:0] fault
);
    // R4: a latched interrupt persists while the clear is inactive
    p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && clr_s) |=> !irq_n);

    // R5: an active clear forces the output inactive
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_s) |=> irq_n);

    // R6: no arming without the power-on request
    p_unarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_on) |-> !live);

    // R7: nothing new interrupts while unarmed (hold-off or power off)
    p_hold_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!live && irq_n) |=> irq_n);

    // R7: nothing is recorded while unarmed and no write happens
    p_hold_rec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!live && !wr_en) |=> $stable(fault));

    // R8: fault bits never drop without a write
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ((fault & $past(fault)) == $past(fault)));
endmodule

bind irq_fault_capture irqf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .wr_en(wr_en),
    .clr_s(clr_s), .live(live), .irq_n(irq_n), .fault(fault_q)
);

// File: tb/irq_fault_capture_tb.sv
`timescale 1ns/1ps
module irq_fault_capture_tb;
    localparam int UNIT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0, pwr_on = 1'b0, clr_n = 1'b1;
    logic [3:0] ev_ov_in, ev_uv_in, ev_uv1_out, ev_uv2_out, ev_oc, ev_trk;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_n;
    logic [23:0] src = '0;

    int nvec = 0, nerr = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // stated layout: supply k (0-based) sits at bit (7-k) / (3-k) of its byte
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            ev_uv_in[k]   = src[23-k];
            ev_ov_in[k]   = src[19-k];
            ev_uv1_out[k] = src[15-k];
            ev_uv2_out[k] = src[11-k];
            ev_trk[k]     = src[7-k];
            ev_oc[k]      = src[3-k];
        end
    end

    irq_fault_capture #(.HOLD_UNIT_MS(UNIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pwr_on(pwr_on), .clr_n(clr_n),
        .ev_ov_in(ev_ov_in), .ev_uv_in(ev_uv_in), .ev_uv1_out(ev_uv1_out),
        .ev_uv2_out(ev_uv2_out), .ev_oc(ev_oc), .ev_trk(ev_trk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a; #0.1; v = rd_data;
    endtask

    task automatic rd_faults(output logic [23:0] v);
        logic [7:0] b;
        rd(3'd4, b); v[23:16] = b;
        rd(3'd5, b); v[15:8]  = b;
        rd(3'd6, b); v[7:0]   = b;
    endtask

    task automatic set_en(input logic [23:0] e);
        wr(3'd0, e[23:16]); wr(3'd1, e[15:8]); wr(3'd2, e[7:0]);
    endtask

    task automatic clear_all();
        clr_n = 1'b0; step(4); clr_n = 1'b1; step(4);
        wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'h00);
    endtask

    function automatic int hold_ticks(input int c);
        if (c == 0) return 0;
        return UNIT << ((c >= 4) ? 3 : c - 1);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [23:0] f;
        step(3);
        rst_n = 1'b1;
        step(2);

        // R1 reset state
        chk("R1 irq_n", irq_n, 1);
        rd(3'd0, b); chk("R1 en0", b, 8'hFF);
        rd(3'd1, b); chk("R1 en1", b, 8'hFF);
        rd(3'd2, b); chk("R1 en2 R9", b, 8'h0F);
        rd(3'd3, b); chk("R1 hold", b, 8'h04);
        rd_faults(f); chk("R1 faults", f, 0);

        wr(3'd3, 8'h00);
        pwr_on = 1'b1;
        step(3);

        // R2/R3/R4 sweep over all twenty sources
        for (int p = 0; p < 24; p++) begin
            if (p >= 4 && p <= 7) continue;
            set_en(24'hFFFF0F & ~(24'h1 << p));
            src = 24'h1 << p;
            step(3);
            chk($sformatf("R3 irq masked p%0d", p), irq_n, 1);
            rd_faults(f); chk($sformatf("R3 fault masked p%0d", p), f, 0);
            src = '0;
            set_en(24'h1 << p);
            src = 24'hFFFF0F;
            step(3);
            chk($sformatf("R2 irq p%0d", p), irq_n, 0);
            rd_faults(f); chk($sformatf("R2 fault p%0d", p), f, 24'h1 << p);
            src = '0;
            step(6);
            chk($sformatf("R4 latched p%0d", p), irq_n, 0);
            clr_n = 1'b0; step(4);
            chk($sformatf("R4 cleared p%0d", p), irq_n, 1);
            clr_n = 1'b1; step(4);
            chk($sformatf("R4 stays clear p%0d", p), irq_n, 1);
            clear_all();
        end
        set_en(24'hFFFF0F);

        // R9 tracking bits record but never interrupt
        for (int k = 0; k < 4; k++) begin
            src = 24'h1 << (7 - k);
            step(3);
            chk($sformatf("R9 irq trk%0d", k), irq_n, 1);
            rd(3'd6, b); chk($sformatf("R9 fault trk%0d", k), b, 8'h80 >> k);
            src = '0;
            clear_all();
        end

        // R8 write-to-clear semantics
        src = 24'hFFFFFF; step(2); src = '0; step(1);
        rd_faults(f); chk("R8 all set", f, 24'hFFFFFF);
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'h5A);
        wr(3'd6, 8'h00);
        step(2);
        rd_faults(f); chk("R8 and-clear", f, 24'hFF5A00);
        clear_all();

        // R5 clear held low masks, release re-asserts
        src = 24'h080000;
        clr_n = 1'b0;
        step(4);
        chk("R5 held clear", irq_n, 1);
        step(4);
        chk("R5 held clear later", irq_n, 1);
        clr_n = 1'b1;
        step(4);
        chk("R5 reassert", irq_n, 0);
        src = '0;
        clear_all();

        // R6 no capture while power request inactive
        pwr_on = 1'b0;
        step(2);
        src = 24'hFFFFFF;
        step(5);
        chk("R6 irq", irq_n, 1);
        rd_faults(f); chk("R6 faults", f, 0);
        src = '0;
        step(2);

        // R7 hold-off per code
        for (int c = 0; c < 6; c++) begin
            int h;
            h = hold_ticks(c);
            wr(3'd3, 8'(c));
            src = 24'h080000;
            pwr_on = 1'b1;
            step(1);
            for (int t = 0; t < h; t++) begin
                step(1);
                chk($sformatf("R7 hold c%0d t%0d", c, t), irq_n, 1);
                tick_ms = 1'b1; step(1); tick_ms = 1'b0;
            end
            rd_faults(f); chk($sformatf("R7 no record c%0d", c), f, 0);
            step(2);
            chk($sformatf("R7 expire c%0d", c), irq_n, 0);
            rd_faults(f); chk($sformatf("R7 record c%0d", c), f, 24'h080000);
            src = '0;
            pwr_on = 1'b0;
            step(1);
            clear_all();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule